// File: doc/BRIEF.md
# SEC-DED Syndrome Classifier

This block sits behind the check-bit comparator of a 64-bit protected memory path. It receives the 8-bit syndrome, which is the XOR of the stored check bits and the check bits regenerated from the data read back. It sorts that syndrome into one of five outcomes:

- no error;
- one data bit wrong, with the bit's position;
- one check bit wrong, with the check bit's position;
- two bits wrong;
- three or more bits wrong.

The correction stage downstream uses the data position to flip the faulty bit. Error accounting logic can treat check-bit faults, double faults and wider faults separately instead of merging them into one uncorrectable flag.

The code matrix has one column per data bit, and each column is a distinct odd-weight 8-bit pattern. The generator uses the same matrix. Check bit i owns the single-bit column with only bit i set. Because every column has odd weight, any two-bit fault gives a nonzero even-weight syndrome. An odd-weight syndrome that matches no column shows that at least three bits are wrong. The decode is combinational. A parameter places a register stage at the output, and this register is present by default.

Top module: `secded_syn_classify`

## Requirements
- R1: The class output is encoded as 0 = none, 1 = single data bit, 2 = single check bit, 3 = double, 4 = three or more. With the default REG_OUT = 1, the result for a syndrome appears on the outputs one clock after that syndrome is sampled.
- R2: A syndrome of all zeros gives class 0.
- R3: The column of data bit i is the i-th entry in a fixed list. The list holds all 8-bit values of weight 3 in ascending numeric order, then the eight smallest 8-bit values of weight 5 in ascending order. A syndrome equal to the column of data bit i gives class 1 and a data index of i.
- R4: A syndrome with only bit i set gives class 2 and a check index of i.
- R5: Every nonzero syndrome of even weight gives class 3.
- R6: An odd-weight syndrome that is neither a data column nor a check column gives class 4.
- R7: The data index is 0 whenever the class is not 1. The check index is 0 whenever the class is not 2.
- R8: While rst is high, the registered outputs are driven to class 0 with both indices 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| syndrome | input | 8 | Stored check bits XOR regenerated check bits |
| err_class | output | 3 | Outcome code (see R1) |
| data_idx | output | 6 | Position of the failing data bit |
| chk_idx | output | 3 | Position of the failing check bit |

## Verification
Every result is due exactly one rising edge after its syndrome is presented. The driver changes the syndrome on a falling edge and queues the expected outcome in the same cycle. The monitor removes one entry from the queue shortly after each following rising edge and compares it against all three outputs there, so the queue depth stays one cycle behind the stimulus. The reset check samples just after a rising edge taken with rst high, once the queue has drained.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int SYN_W     = 8;
    localparam int DATA_BITS = 64;
    localparam int DIDX_W    = $clog2(DATA_BITS);
    localparam int CIDX_W    = $clog2(SYN_W);
    localparam int LO_WEIGHT = 3;
    localparam int HI_WEIGHT = 5;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_DATA   = 3'd1,
        ERR_CHECK  = 3'd2,
        ERR_DOUBLE = 3'd3,
        ERR_MULTI  = 3'd4
    } err_cls_e;

    typedef struct packed {
        err_cls_e              cls;
        logic [DIDX_W-1:0]     didx;
        logic [CIDX_W-1:0]     cidx;
    } verdict_t;

    function automatic int bit_weight(logic [SYN_W-1:0] v);
        int n;
        n = 0;
        for (int b = 0; b < SYN_W; b++) n += int'(v[b]);
        return n;
    endfunction

    // Column of data bit idx: weight-3 values ascending, then weight-5 ascending.
    function automatic logic [SYN_W-1:0] data_col(int idx);
        int               seen;
        logic [SYN_W-1:0] pick;
        seen = 0;
        pick = '0;
        for (int w = LO_WEIGHT; w <= HI_WEIGHT; w += 2) begin
            for (int v = 0; v < (1 << SYN_W); v++) begin
                if (bit_weight(SYN_W'(v)) == w) begin
                    if (seen == idx) pick = SYN_W'(v);
                    seen++;
                end
            end
        end
        return pick;
    endfunction

endpackage

// File: rtl/secded_data_match.sv
module secded_data_match
    import secded_pkg::*;
(
    input  logic [SYN_W-1:0]  syn,
    output logic              hit,
    output logic [DIDX_W-1:0] idx
);
    logic [DATA_BITS-1:0] col_hit;

    for (genvar g = 0; g < DATA_BITS; g++) begin : g_col
        localparam logic [SYN_W-1:0] COL = data_col(g);
        assign col_hit[g] = (syn == COL);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < DATA_BITS; i++) begin
            if (col_hit[i]) idx = idx | DIDX_W'(i);
        end
    end

    assign hit = |col_hit;
endmodule

// File: rtl/secded_chk_match.sv
module secded_chk_match
    import secded_pkg::*;
(
    input  logic [SYN_W-1:0]  syn,
    output logic              hit,
    output logic [CIDX_W-1:0] idx
);
    assign hit = ($countones(syn) == 1);

    always_comb begin
        idx = '0;
        for (int i = 0; i < SYN_W; i++) begin
            if (syn[i]) idx = idx | CIDX_W'(i);
        end
    end
endmodule

// File: rtl/secded_classify.sv
module secded_classify
    import secded_pkg::*;
(
    input  logic [SYN_W-1:0]  syn,
    input  logic              data_hit,
    input  logic [DIDX_W-1:0] data_pos,
    input  logic              chk_hit,
    input  logic [CIDX_W-1:0] chk_pos,
    output verdict_t          verdict
);
    always_comb begin
        verdict = '{cls: ERR_NONE, didx: '0, cidx: '0};
        if (syn == '0) begin
            verdict.cls = ERR_NONE;
        end else if (data_hit) begin
            verdict.cls  = ERR_DATA;
            verdict.didx = data_pos;
        end else if (chk_hit) begin
            verdict.cls  = ERR_CHECK;
            verdict.cidx = chk_pos;
        end else if (!(^syn)) begin
            verdict.cls = ERR_DOUBLE;
        end else begin
            verdict.cls = ERR_MULTI;
        end
    end
endmodule

// File: rtl/secded_syn_classify.sv
module secded_syn_classify
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [secded_pkg::SYN_W-1:0]  syndrome,
    output logic [2:0]                    err_class,
    output logic [secded_pkg::DIDX_W-1:0] data_idx,
    output logic [secded_pkg::CIDX_W-1:0] chk_idx
);
    logic              d_hit;
    logic [DIDX_W-1:0] d_pos;
    logic              c_hit;
    logic [CIDX_W-1:0] c_pos;
    verdict_t          v_comb;
    verdict_t          v_out;

    secded_data_match u_data (.syn(syndrome), .hit(d_hit), .idx(d_pos));
    secded_chk_match  u_chk  (.syn(syndrome), .hit(c_hit), .idx(c_pos));
    secded_classify   u_cls  (
        .syn(syndrome), .data_hit(d_hit), .data_pos(d_pos),
        .chk_hit(c_hit), .chk_pos(c_pos), .verdict(v_comb)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) v_out <= '{cls: ERR_NONE, didx: '0, cidx: '0};
            else     v_out <= v_comb;
        end
    end else begin : g_comb
        assign v_out = v_comb;
    end

    assign err_class = v_out.cls;
    assign data_idx  = v_out.didx;
    assign chk_idx   = v_out.cidx;
endmodule

// File: rtl/secded_syn_classify_chk.sv
module secded_syn_classify_chk
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [SYN_W-1:0]  syndrome,
    input logic [2:0]        err_class,
    input logic [DIDX_W-1:0] data_idx,
    input logic [CIDX_W-1:0] chk_idx
);
    logic [SYN_W-1:0] syn_q;
    logic             armed;
    logic [SYN_W-1:0] syn_ref;
    int               wt;

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_q <= '0;
            armed <= 1'b0;
        end else begin
            syn_q <= syndrome;
            armed <= 1'b1;
        end
    end

    assign syn_ref = REG_OUT ? syn_q : syndrome;
    assign wt      = $countones(syn_ref);

    assert_zero_none_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && syn_ref == '0) |-> (err_class == 3'd0));

    assert_data_weight_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && err_class == 3'd1) |-> (wt == 3 || wt == 5));

    assert_check_pos_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && err_class == 3'd2) |-> (syn_ref == (SYN_W'(1) << chk_idx)));

    assert_even_double_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && syn_ref != '0 && !(^syn_ref)) |-> (err_class == 3'd3));

    assert_multi_odd_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && err_class == 3'd4) |-> ((^syn_ref) && wt >= 3));

    assert_idx_clear_R7: assert property (@(posedge clk) disable iff (rst)
        armed |-> ((err_class == 3'd1 || data_idx == '0) &&
                   (err_class == 3'd2 || chk_idx == '0)));

    assert_code_range_R1: assert property (@(posedge clk) disable iff (rst)
        armed |-> (err_class <= 3'd4));
endmodule

bind secded_syn_classify secded_syn_classify_chk #(.REG_OUT(REG_OUT)) chk_i (
    .clk(clk), .rst(rst), .syndrome(syndrome),
    .err_class(err_class), .data_idx(data_idx), .chk_idx(chk_idx)
);

// File: tb/secded_syn_classify_tb_top.sv
module secded_syn_classify_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    typedef struct {
        logic [7:0] syn;
        logic [2:0] cls;
        logic [5:0] didx;
        logic [2:0] cidx;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] syndrome = '0;
    logic [2:0] err_class;
    logic [5:0] data_idx;
    logic [2:0] chk_idx;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;
    exp_t sb_q[$];
    logic [7:0] cols[64];

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_syn_classify dut_i (
        .clk(clk), .rst(rst), .syndrome(syndrome),
        .err_class(err_class), .data_idx(data_idx), .chk_idx(chk_idx)
    );

    function automatic int pop8(logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) if (v[b]) n++;
        return n;
    endfunction

    function automatic exp_t model(logic [7:0] s);
        exp_t e;
        e.syn = s; e.cls = 3'd0; e.didx = '0; e.cidx = '0;
        if (s == 8'h00) return e;
        for (int i = 0; i < 64; i++) begin
            if (cols[i] == s) begin e.cls = 3'd1; e.didx = 6'(i); return e; end
        end
        for (int i = 0; i < 8; i++) begin
            if (s == (8'h01 << i)) begin e.cls = 3'd2; e.cidx = 3'(i); return e; end
        end
        e.cls = (pop8(s) % 2 == 0) ? 3'd3 : 3'd4;
        return e;
    endfunction

    function automatic string cls_tag(logic [2:0] c);
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(logic [7:0] s);
        @(negedge clk);
        syndrome = s;
        sb_q.push_back(model(s));
    endtask

    // Monitor: result of the syndrome driven before an edge is due just after it (R1).
    always @(posedge clk) begin
        #1;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (err_class !== e.cls) begin
                n_errors++;
                $display("FAIL %s/R1 syn=%02h class act=%0d exp=%0d",
                         cls_tag(e.cls), e.syn, err_class, e.cls);
            end
            n_checks++;
            if (data_idx !== e.didx || chk_idx !== e.cidx) begin
                n_errors++;
                $display("FAIL %s syn=%02h idx act=%0d/%0d exp=%0d/%0d",
                         (e.cls == 3'd1 || e.cls == 3'd2) ? cls_tag(e.cls) : "R7",
                         e.syn, data_idx, chk_idx, e.didx, e.cidx);
            end
        end
    end

    task automatic check_reset(string tag);
        n_checks++;
        if (err_class !== 3'd0 || data_idx !== '0 || chk_idx !== '0) begin
            n_errors++;
            $display("FAIL %s reset outputs act=%0d/%0d/%0d exp=0/0/0",
                     tag, err_class, data_idx, chk_idx);
        end
    endtask

    initial begin
        int k;
        k = 0;
        for (int w = 3; w <= 5; w += 2)
            for (int v = 0; v < 256; v++)
                if (pop8(8'(v)) == w && k < 64) begin cols[k] = 8'(v); k++; end

        // R8: reset state
        repeat (3) @(posedge clk);
        #1 check_reset("R8");
        @(negedge clk) rst = 1'b0;

        // Exhaustive sweep of all syndromes: R2..R7
        for (int v = 0; v < 256; v++) apply(8'(v));
        // Every single data-bit and check-bit injection (R3, R4)
        for (int i = 0; i < 64; i++) apply(cols[i]);
        for (int i = 0; i < 8; i++) apply(8'h01 << i);
        // Every double injection: data+data, data+check (R5)
        for (int i = 0; i < 64; i++)
            for (int j = i + 1; j < 64; j++) apply(cols[i] ^ cols[j]);
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 8; j++) apply(cols[i] ^ (8'h01 << j));
        // Triple injections (R6, or aliasing onto a single column)
        for (int i = 0; i < 62; i++) apply(cols[i] ^ cols[i+1] ^ cols[i+2]);
        // Back-to-back class changes
        apply(8'h00); apply(8'h80); apply(cols[63]); apply(8'hFF); apply(8'h03); apply(8'h00);

        repeat (3) @(negedge clk);
        // R8: mid-run reset with a nonzero syndrome applied
        syndrome = cols[5];
        rst = 1'b1;
        @(posedge clk);
        #1 check_reset("R8");
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule